// File: doc/BRIEF.md
# Multiword DMA Request Handshake (Device Side)

This block is the device end of a multiword DMA exchange on a 16-bit parallel IDE-style data bus. Local logic arms a burst by giving a word count and a direction. Once the device's buffer reports that it can source or sink data, the block raises its request line toward the host. It holds that request until the host acknowledges. It then moves one 16-bit word for each rising edge of the strobe that matches the direction. It counts the words down and ends the burst with a one-cycle done pulse after the last word.

The host's acknowledge, its strobes and its write data pass through a parameterised alignment pipeline before the logic acts on them. All block signals are active high; any inversion happens at the pads. The request line has its own output enable, which follows the device-select input, so the pad floats while the device is not selected. Either chip select asserted while a burst is in progress raises a per-cycle error flag.

Top module: `mdma_dev_handshake`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `dmarq`, `dmarq_oe`, `done`, `cs_err`, `wr_valid` and `rd_take` are 0, and `words_left` is 0.
- R2: In the idle state, a `start` pulse with a nonzero `start_words` loads `words_left` and latches the direction (`start_rd` = 1 means device to host). A `start` with a zero count, or any `start` while a burst is active, has no effect on `words_left`.
- R3: Once a burst is loaded, `dmarq` rises on the clock edge that samples `buf_ready` high. It stays low while `buf_ready` is low.
- R4: After `dmarq` rises it stays high until the aligned acknowledge is seen. It remains high while the acknowledge is held and words are still owed.
- R5: A word moves only on a rising edge of `rd_stb` (read burst) or `wr_stb` (write burst) while the aligned acknowledge is high. Edges of the other strobe, and edges while acknowledge is low, change nothing. The effect appears SYNC_STAGES+1 cycles after the edge is first sampled.
- R6: A write word gives a one-cycle `wr_valid` pulse, with `wr_word` equal to the `host_wdata` that was sampled with the strobe edge. A read word gives a one-cycle `rd_take` pulse. During the transfer phase of a read burst, `bus_oe` is high and `bus_dout` equals `dev_rdata`.
- R7: `words_left` drops by exactly one for each word moved.
- R8: When the last word moves, `done` pulses for one cycle and `dmarq` falls in the same cycle. The block returns to idle once the acknowledge is released.
- R9: If the host releases the acknowledge while words remain, `dmarq` falls. It is raised again once `buf_ready` is seen, and `words_left` is kept.
- R10: `dmarq_oe` equals `sel` delayed by one clock, whatever the state of the burst.
- R11: `cs_err` is high in the cycle after `cs0` or `cs1` was sampled high while a burst was active (not idle). It stays low in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Device selected |
| cs0 | input | 1 | Chip select 0, asserted high |
| cs1 | input | 1 | Chip select 1, asserted high |
| start | input | 1 | Arm a burst |
| start_words | input | CNT_W | Words in the burst |
| start_rd | input | 1 | 1: device to host, 0: host to device |
| buf_ready | input | 1 | Buffer can source or sink a word |
| dmack | input | 1 | Host DMA acknowledge |
| rd_stb | input | 1 | Host read strobe |
| wr_stb | input | 1 | Host write strobe |
| host_wdata | input | DATA_W | Bus data from host |
| dev_rdata | input | DATA_W | Buffer head word for reads |
| dmarq | output | 1 | DMA request value |
| dmarq_oe | output | 1 | Request pad output enable |
| bus_dout | output | DATA_W | Data driven to host |
| bus_oe | output | 1 | Data bus output enable |
| wr_word | output | DATA_W | Word captured from host |
| wr_valid | output | 1 | Write word pulse |
| rd_take | output | 1 | Read word consumed pulse |
| words_left | output | CNT_W | Remaining words |
| done | output | 1 | Last word moved |
| cs_err | output | 1 | Chip select seen during burst |

## Verification
The bench builds the block with CNT_W = 4 and SYNC_STAGES = 2. The narrow counter makes a full-scale burst of 15 words short enough to run. The two-stage alignment makes the delay of acknowledge and strobe edges visible, so the model's timing for each word, for the release of the acknowledge and for the re-raise of the request is tested against cycles that actually differ.

// File: rtl/mdma_pkg.sv
package mdma_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ARMED = 3'd1,
      ST_REQ   = 3'd2,
      ST_XFER  = 3'd3,
      ST_DRAIN = 3'd4
   } mdma_state_t;
endpackage

// File: rtl/mdma_align.sv
module mdma_align #(
   parameter int W      = 19,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] d_out
);
   generate
      if (STAGES == 0) begin : g_pass
         assign d_out = d_in;
      end else begin : g_pipe
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= '0;
            end else begin
               stg[0] <= d_in;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign d_out = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/mdma_word_cnt.sv
module mdma_word_cnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic [CNT_W-1:0] count,
   output logic             is_last
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   always_ff @(posedge clk) begin
      if (rst)       count <= '0;
      else if (load) count <= load_val;
      else if (dec)  count <= count - ONE;
   end

   assign is_last = (count == ONE);
endmodule

// File: rtl/mdma_seq.sv
module mdma_seq
   import mdma_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  logic        start_ok,
   input  logic        start_rd,
   input  logic        buf_ready,
   input  logic        ack_s,
   input  logic        rd_rise,
   input  logic        wr_rise,
   input  logic        is_last,
   input  logic        cs_any,
   output mdma_state_t state,
   output logic        dir_rd,
   output logic        load,
   output logic        take,
   output logic        dmarq,
   output logic        done,
   output logic        cs_err
);
   mdma_state_t nxt;
   logic        edge_hit;

   assign edge_hit = dir_rd ? rd_rise : wr_rise;
   assign load     = (state == ST_IDLE) && start_ok;
   assign take     = (state == ST_XFER) && ack_s && edge_hit;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:  if (start_ok)  nxt = ST_ARMED;
         ST_ARMED: if (buf_ready) nxt = ST_REQ;
         ST_REQ:   if (ack_s)     nxt = ST_XFER;
         ST_XFER: begin
            if (!ack_s)               nxt = ST_ARMED;
            else if (take && is_last) nxt = ST_DRAIN;
         end
         ST_DRAIN: if (!ack_s)    nxt = ST_IDLE;
         default:                 nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state  <= ST_IDLE;
         dir_rd <= 1'b0;
         dmarq  <= 1'b0;
         done   <= 1'b0;
         cs_err <= 1'b0;
      end else begin
         state  <= nxt;
         if (load) dir_rd <= start_rd;
         dmarq  <= (nxt == ST_REQ) || (nxt == ST_XFER);
         done   <= take && is_last;
         cs_err <= (state != ST_IDLE) && cs_any;
      end
   end
endmodule

// File: rtl/mdma_dev_handshake.sv
module mdma_dev_handshake
   import mdma_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sel,
   input  logic              cs0,
   input  logic              cs1,
   input  logic              start,
   input  logic [CNT_W-1:0]  start_words,
   input  logic              start_rd,
   input  logic              buf_ready,
   input  logic              dmack,
   input  logic              rd_stb,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic [DATA_W-1:0] dev_rdata,
   output logic              dmarq,
   output logic              dmarq_oe,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_oe,
   output logic [DATA_W-1:0] wr_word,
   output logic              wr_valid,
   output logic              rd_take,
   output logic [CNT_W-1:0]  words_left,
   output logic              done,
   output logic              cs_err
);
   localparam int AW = DATA_W + 3;

   initial begin : p_param_check
      if (CNT_W < 2)                          $error("CNT_W must be at least 2");
      if (DATA_W != 16)                       $error("DMA words are 16 bits");
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) $error("SYNC_STAGES out of 0..4");
   end

   logic [AW-1:0]     raw_in, aligned;
   logic              ack_s, rd_s, wr_s, rd_q, wr_q;
   logic [DATA_W-1:0] wdata_s;
   logic              rd_rise, wr_rise, start_ok, load, take, is_last, dir_rd;
   logic              st_req, busy;
   mdma_state_t       state;

   assign raw_in = {dmack, rd_stb, wr_stb, host_wdata};

   mdma_align #(.W(AW), .STAGES(SYNC_STAGES)) u_align (
      .clk(clk), .rst(rst), .d_in(raw_in), .d_out(aligned)
   );

   assign ack_s   = aligned[AW-1];
   assign rd_s    = aligned[AW-2];
   assign wr_s    = aligned[AW-3];
   assign wdata_s = aligned[DATA_W-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_q <= 1'b0;
         wr_q <= 1'b0;
      end else begin
         rd_q <= rd_s;
         wr_q <= wr_s;
      end
   end

   assign rd_rise  = rd_s && !rd_q;
   assign wr_rise  = wr_s && !wr_q;
   assign start_ok = start && (start_words != '0);

   mdma_seq u_seq (
      .clk(clk), .rst(rst), .start_ok(start_ok), .start_rd(start_rd),
      .buf_ready(buf_ready), .ack_s(ack_s), .rd_rise(rd_rise), .wr_rise(wr_rise),
      .is_last(is_last), .cs_any(cs0 || cs1), .state(state), .dir_rd(dir_rd),
      .load(load), .take(take), .dmarq(dmarq), .done(done), .cs_err(cs_err)
   );

   mdma_word_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .load(load), .load_val(start_words),
      .dec(take), .count(words_left), .is_last(is_last)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         dmarq_oe <= 1'b0;
         wr_valid <= 1'b0;
         rd_take  <= 1'b0;
         wr_word  <= '0;
      end else begin
         dmarq_oe <= sel;
         wr_valid <= take && !dir_rd;
         rd_take  <= take && dir_rd;
         if (take && !dir_rd) wr_word <= wdata_s;
      end
   end

   assign bus_oe   = (state == ST_XFER) && dir_rd;
   assign bus_dout = dev_rdata;
   assign st_req   = (state == ST_REQ);
   assign busy     = (state != ST_IDLE);
endmodule

// File: rtl/mdma_dev_handshake_chk.sv
module mdma_dev_handshake_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             sel,
   input logic             cs0,
   input logic             cs1,
   input logic             dmarq,
   input logic             dmarq_oe,
   input logic             done,
   input logic             cs_err,
   input logic [CNT_W-1:0] words_left,
   input logic             wr_valid,
   input logic             rd_take,
   input logic             ack_s,
   input logic             st_req,
   input logic             busy
);
   a_r4_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
      (st_req && !ack_s) |=> dmarq);
   a_r3_idle_no_req: assert property (@(posedge clk) disable iff (rst)
      !busy |-> !dmarq);
   a_r10_oe_on: assert property (@(posedge clk) disable iff (rst)
      sel |=> dmarq_oe);
   a_r10_oe_off: assert property (@(posedge clk) disable iff (rst)
      !sel |=> !dmarq_oe);
   a_r11_cs_flag: assert property (@(posedge clk) disable iff (rst)
      (busy && (cs0 || cs1)) |=> cs_err);
   a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      !busy |=> !cs_err);
   a_r8_done_empty: assert property (@(posedge clk) disable iff (rst)
      done |-> (words_left == '0 && !dmarq));
   a_r6_one_dir: assert property (@(posedge clk) disable iff (rst)
      $onehot0({wr_valid, rd_take}));
   a_r7_step: assert property (@(posedge clk) disable iff (rst)
      (wr_valid || rd_take) |-> (words_left == CNT_W'($past(words_left) - 1'b1)));
endmodule

bind mdma_dev_handshake mdma_dev_handshake_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst(rst), .sel(sel), .cs0(cs0), .cs1(cs1), .dmarq(dmarq),
   .dmarq_oe(dmarq_oe), .done(done), .cs_err(cs_err), .words_left(words_left),
   .wr_valid(wr_valid), .rd_take(rd_take), .ack_s(ack_s), .st_req(st_req),
   .busy(busy)
);

// File: tb/mdma_dev_handshake_test.sv
module mdma_dev_handshake_test;
   localparam int CNT_W = 4;
   localparam int DW    = 16;
   localparam int SYNC  = 2;
   localparam int P_IDLE = 0, P_ARM = 1, P_REQ = 2, P_XFER = 3, P_DRAIN = 4;

   logic clk = 1'b0;
   logic rst, sel, cs0, cs1, start, start_rd, buf_ready, dmack, rd_stb, wr_stb;
   logic [CNT_W-1:0] start_words;
   logic [DW-1:0]    host_wdata, dev_rdata;
   logic             dmarq, dmarq_oe, bus_oe, wr_valid, rd_take, done, cs_err;
   logic [DW-1:0]    bus_dout, wr_word;
   logic [CNT_W-1:0] words_left;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   mdma_dev_handshake #(.CNT_W(CNT_W), .DATA_W(DW), .SYNC_STAGES(SYNC)) uut (
      .clk(clk), .rst(rst), .sel(sel), .cs0(cs0), .cs1(cs1), .start(start),
      .start_words(start_words), .start_rd(start_rd), .buf_ready(buf_ready),
      .dmack(dmack), .rd_stb(rd_stb), .wr_stb(wr_stb), .host_wdata(host_wdata),
      .dev_rdata(dev_rdata), .dmarq(dmarq), .dmarq_oe(dmarq_oe), .bus_dout(bus_dout),
      .bus_oe(bus_oe), .wr_word(wr_word), .wr_valid(wr_valid), .rd_take(rd_take),
      .words_left(words_left), .done(done), .cs_err(cs_err)
   );

   // reference model state
   bit q_ack[$];
   bit q_rd[$];
   bit q_wr[$];
   logic [DW-1:0] q_d[$];
   bit c_ack, c_rd, c_wr, p_rd, p_wr, e_rd, e_wr;
   logic [DW-1:0] c_d;
   int  m_phase, m_cnt;
   bit  m_dir, m_dmarq, m_oe, m_done, m_wv, m_rt, m_cs_err;
   logic [DW-1:0] m_wword;

   always @(posedge clk) begin
      cycles++;
      if (rst) begin
         q_ack.delete(); q_rd.delete(); q_wr.delete(); q_d.delete();
         p_rd = 0; p_wr = 0; m_phase = P_IDLE; m_cnt = 0; m_dir = 0;
         m_oe = 0; m_done = 0; m_wv = 0; m_rt = 0; m_cs_err = 0; m_wword = '0;
      end else begin
         q_ack.push_back(dmack); q_rd.push_back(rd_stb);
         q_wr.push_back(wr_stb); q_d.push_back(host_wdata);
         if (q_ack.size() > SYNC) begin
            c_ack = q_ack.pop_front(); c_rd = q_rd.pop_front();
            c_wr = q_wr.pop_front(); c_d = q_d.pop_front();
         end else begin
            c_ack = 0; c_rd = 0; c_wr = 0; c_d = '0;
         end
         e_rd = c_rd && !p_rd;
         e_wr = c_wr && !p_wr;
         m_cs_err = (m_phase != P_IDLE) && (cs0 || cs1);
         m_oe = sel;
         m_done = 0; m_wv = 0; m_rt = 0;
         case (m_phase)
            P_IDLE: if (start && start_words != 0) begin
               m_cnt = start_words; m_dir = start_rd; m_phase = P_ARM;
            end
            P_ARM: if (buf_ready) m_phase = P_REQ;
            P_REQ: if (c_ack) m_phase = P_XFER;
            P_XFER: begin
               if (!c_ack) m_phase = P_ARM;
               else if (m_dir ? e_rd : e_wr) begin
                  m_cnt = m_cnt - 1;
                  if (m_dir) m_rt = 1;
                  else begin m_wv = 1; m_wword = c_d; end
                  if (m_cnt == 0) begin m_done = 1; m_phase = P_DRAIN; end
               end
            end
            P_DRAIN: if (!c_ack) m_phase = P_IDLE;
            default: m_phase = P_IDLE;
         endcase
         p_rd = c_rd; p_wr = c_wr;
      end
      m_dmarq = (m_phase == P_REQ) || (m_phase == P_XFER);
   end

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(posedge clk) begin
      #2;
      chk("R4", "dmarq", dmarq, m_dmarq);
      chk("R10", "dmarq_oe", dmarq_oe, m_oe);
      chk("R7", "words_left", words_left, m_cnt);
      chk("R8", "done", done, m_done);
      chk("R6", "wr_valid", wr_valid, m_wv);
      chk("R6", "rd_take", rd_take, m_rt);
      chk("R6", "wr_word", wr_word, m_wword);
      chk("R6", "bus_oe", bus_oe, (m_phase == P_XFER) && m_dir);
      if (bus_oe) chk("R6", "bus_dout", bus_dout, dev_rdata);
      chk("R11", "cs_err", cs_err, m_cs_err);
   end

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      if (cycles > 20000) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic strobe(bit is_rd, logic [DW-1:0] d);
      @(negedge clk);
      if (is_rd) begin rd_stb = 1; dev_rdata = d; end
      else begin wr_stb = 1; host_wdata = d; end
      cyc(2);
      rd_stb = 0; wr_stb = 0;
      cyc(2);
   endtask

   task automatic arm(int n, bit rd);
      @(negedge clk);
      start = 1; start_words = CNT_W'(n); start_rd = rd;
      @(negedge clk);
      start = 0;
   endtask

   initial begin
      rst = 1; sel = 1; cs0 = 0; cs1 = 0; start = 0; start_rd = 0; buf_ready = 0;
      dmack = 0; rd_stb = 0; wr_stb = 0; start_words = '0;
      host_wdata = '0; dev_rdata = '0;
      cyc(3);
      chk("R1", "dmarq", dmarq, 0);
      chk("R1", "dmarq_oe", dmarq_oe, 0);
      chk("R1", "words_left", words_left, 0);
      chk("R1", "done", done, 0);
      rst = 0;
      @(negedge clk);
      chk("R1", "wr_valid", wr_valid, 0);
      cyc(2);

      // R2: zero count is ignored
      buf_ready = 1;
      arm(0, 0); cyc(3);
      chk("R2", "words_left zero start", words_left, 0);
      chk("R2", "dmarq zero start", dmarq, 0);

      // write burst of 3
      arm(3, 0); cyc(1);
      chk("R3", "dmarq after ready", dmarq, 1);
      chk("R2", "words_left loaded", words_left, 3);
      cyc(4);
      chk("R4", "dmarq held without ack", dmarq, 1);
      strobe(0, 16'h1111);
      chk("R5", "strobe without ack", words_left, 3);
      dmack = 1; cyc(4);
      strobe(0, 16'hA001);
      chk("R7", "words_left after word", words_left, 2);
      chk("R6", "wr_word", wr_word, 16'hA001);
      strobe(1, 16'h5555);
      chk("R5", "opposite strobe", words_left, 2);
      strobe(0, 16'hA002);
      strobe(0, 16'hA003);
      chk("R8", "words_left end", words_left, 0);
      chk("R8", "dmarq end", dmarq, 0);
      dmack = 0; cyc(5);

      // read burst of 4, buffer not ready at first
      buf_ready = 0;
      arm(4, 1); cyc(5);
      chk("R3", "dmarq while not ready", dmarq, 0);
      buf_ready = 1; cyc(2);
      chk("R3", "dmarq once ready", dmarq, 1);
      dmack = 1; cyc(4);
      strobe(1, 16'hB001);
      strobe(1, 16'hB002);
      chk("R7", "words_left read", words_left, 2);
      cs0 = 1; @(negedge clk);
      chk("R11", "cs_err in burst", cs_err, 1);
      cs0 = 0;
      arm(9, 0); cyc(2);
      chk("R2", "start while busy", words_left, 2);
      dmack = 0; cyc(3);
      chk("R9", "dmarq dropped", dmarq, 0);
      cyc(5);
      chk("R9", "dmarq re-raised", dmarq, 1);
      chk("R9", "words kept", words_left, 2);
      dmack = 1; cyc(4);
      strobe(1, 16'hB003);
      strobe(1, 16'hB004);
      chk("R8", "read burst end", words_left, 0);
      dmack = 0; cyc(5);

      // R10: output enable follows select
      sel = 0; cyc(3);
      chk("R10", "oe with sel low", dmarq_oe, 0);
      sel = 1; cyc(2);
      chk("R10", "oe with sel high", dmarq_oe, 1);

      // R11: chip select in idle is not an error
      cs1 = 1; cyc(3);
      chk("R11", "cs in idle", cs_err, 0);
      cs1 = 0;

      // full-scale write burst
      arm(15, 0); cyc(2);
      dmack = 1; cyc(4);
      for (int i = 0; i < 15; i++) strobe(0, 16'hC000 + 16'(i));
      chk("R8", "full burst end", words_left, 0);
      chk("R6", "last word", wr_word, 16'hC00E);
      dmack = 0; cyc(6);
      chk("R8", "back to idle", dmarq, 0);
      finish_run();
   end
endmodule